// File: doc/BRIEF.md
# Combinational Restoring Array Divider

This block divides one unsigned 32-bit operand by another and presents both the quotient and the remainder. It is purely combinational. There is no clock, no register and no handshake. Both results are valid once the operands have settled through the array. A parent design registers the outputs at whatever point its own timing allows.

The array has one row for each quotient bit, and the rows are resolved from the most significant bit down. Each row takes the partial remainder from the row above and shifts in the next dividend bit. It then attempts to subtract the divisor, using a width one bit wider than the divisor. The subtraction is carried out by a ripple chain of single-bit borrow cells. The borrow leaving the top of the chain decides the row's outcome:

- If the trial difference is not negative, the difference moves on to the next row and the quotient bit is 1.
- Otherwise, the shifted value moves on unchanged and the quotient bit is 0.

No row ever forwards a negative value, so the scheme is a restoring one.

A zero divisor needs no special logic. Every trial subtraction succeeds, so the quotient comes out all ones and the remainder equals the dividend. This result is the documented convention for that case.

Top module: `restoring_array_divider`

## Requirements
- R1: For a nonzero divisor, `quotient_o` equals the dividend divided by the divisor, rounded toward zero.
- R2: For a nonzero divisor, `remainder_o` equals the dividend modulo the divisor, and is therefore strictly below the divisor.
- R3: Dividing 0x13579BDF by 0x2468 gives quotient 0x00008802 and remainder 0x0000130F.
- R4: With a zero divisor, `quotient_o` is 0xFFFFFFFF and `remainder_o` equals the dividend.
- R5: With a divisor of 1, `quotient_o` equals the dividend and `remainder_o` is 0.
- R6: With a divisor larger than the dividend, `quotient_o` is 0 and `remainder_o` equals the dividend.
- R7: With equal nonzero operands, `quotient_o` is 1 and `remainder_o` is 0.
- R8: For a nonzero divisor, quotient times divisor plus remainder, computed at 64 bits, equals the dividend. This holds up to the extreme operands 0xFFFFFFFF and 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend_i | input | 32 | Unsigned dividend |
| divisor_i | input | 32 | Unsigned divisor |
| quotient_o | output | 32 | Unsigned quotient, all ones for a zero divisor |
| remainder_o | output | 32 | Unsigned remainder, the dividend for a zero divisor |

## Verification
The bench builds the divider with its default width of 32. This gives all 32 rows and the full 33-bit borrow chain in each row. At this width the known vector from R3 can be checked directly, and operands with the top bit set can be applied. Those operands exercise the extra subtract bit that keeps a shifted partial remainder from overflowing. The bench compares each result against the language's own division and modulo operators, applied to random operands and to the corner cases listed in the requirements.

// File: rtl/div_pkg.sv
package div_pkg;

    localparam int unsigned DIV_W = 32;

    typedef struct packed {
        logic diff;
        logic bout;
    } sub_bit_t;

    function automatic sub_bit_t sub_bit(input logic a, input logic b, input logic bin);
        sub_bit_t r;
        r.diff = a ^ b ^ bin;
        r.bout = (~a & b) | (~(a ^ b) & bin);
        return r;
    endfunction

endpackage

// File: rtl/cs_bit_cell.sv
module cs_bit_cell
    import div_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic bin_i,
    output logic diff_o,
    output logic bout_o
);
    sub_bit_t res;

    always_comb begin
        res    = sub_bit(a_i, b_i, bin_i);
        diff_o = res.diff;
        bout_o = res.bout;
    end
endmodule

// File: rtl/cs_row.sv
module cs_row #(
    parameter int unsigned W = div_pkg::DIV_W
) (
    input  logic [W-1:0] prem_i,
    input  logic         dbit_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] prem_o,
    output logic         qbit_o
);
    localparam int unsigned SW = W + 1;

    logic [SW-1:0] shifted;
    logic [SW-1:0] subtrahend;
    logic [SW-1:0] diff;
    logic [SW:0]   borrow;

    assign shifted    = {prem_i, dbit_i};
    assign subtrahend = {1'b0, divisor_i};
    assign borrow[0]  = 1'b0;

    for (genvar k = 0; k < SW; k++) begin : g_cell
        cs_bit_cell cell_i (
            .a_i    (shifted[k]),
            .b_i    (subtrahend[k]),
            .bin_i  (borrow[k]),
            .diff_o (diff[k]),
            .bout_o (borrow[k+1])
        );
    end

    assign qbit_o = ~borrow[SW];
    assign prem_o = qbit_o ? diff[W-1:0] : shifted[W-1:0];
endmodule

// File: rtl/restoring_array_divider.sv
module restoring_array_divider #(
    parameter int unsigned W = div_pkg::DIV_W
) (
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o
);
    logic [W-1:0] prem [W+1];

    assign prem[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_row
        cs_row #(.W(W)) row_i (
            .prem_i    (prem[i]),
            .dbit_i    (dividend_i[W-1-i]),
            .divisor_i (divisor_i),
            .prem_o    (prem[i+1]),
            .qbit_o    (quotient_o[W-1-i])
        );
    end

    assign remainder_o = prem[W];
endmodule

// File: rtl/div_chk.sv
module div_chk #(
    parameter int unsigned W = div_pkg::DIV_W
) (
    input logic [W-1:0] dividend_i,
    input logic [W-1:0] divisor_i,
    input logic [W-1:0] quotient_o,
    input logic [W-1:0] remainder_o
);
    localparam int unsigned DW = 2 * W;

    logic [DW-1:0] recon;
    assign recon = ({{W{1'b0}}, quotient_o} * {{W{1'b0}}, divisor_i}) + {{W{1'b0}}, remainder_o};

    always_comb begin
        if (divisor_i != '0) begin
            AST_REM_BELOW_DIVISOR: assert (remainder_o < divisor_i); // R2
            AST_RECONSTRUCT: assert (recon == {{W{1'b0}}, dividend_i}); // R8
        end
        if (divisor_i == '0) begin
            AST_ZERO_DIV: assert (quotient_o == '1 && remainder_o == dividend_i); // R4
        end
        if (divisor_i > dividend_i) begin
            AST_SMALL_DIVIDEND: assert (quotient_o == '0 && remainder_o == dividend_i); // R6
        end
        if (divisor_i == {{(W-1){1'b0}}, 1'b1}) begin
            AST_UNIT_DIVISOR: assert (quotient_o == dividend_i && remainder_o == '0); // R5
        end
    end
endmodule

bind restoring_array_divider div_chk #(.W(W)) chk_i (
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o)
);

// File: tb/restoring_array_divider_tb.sv
module restoring_array_divider_tb_top;
    localparam int unsigned W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] q;
    logic [W-1:0] r;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    restoring_array_divider #(.W(W)) dut_i (
        .dividend_i  (a),
        .divisor_i   (b),
        .quotient_o  (q),
        .remainder_o (r)
    );

    task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, a, b, act, exp);
        end
    endtask

    task automatic apply(input string tq, input string tr, input logic [W-1:0] na, input logic [W-1:0] nb);
        logic [W-1:0] eq;
        logic [W-1:0] er;
        @(posedge clk);
        a <= na;
        b <= nb;
        @(negedge clk);
        if (nb == '0) begin
            eq = '1;
            er = na;
        end else begin
            eq = na / nb;
            er = na % nb;
        end
        cmp(tq, q, eq);
        cmp(tr, r, er);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp("R4 q after reset", q, '1);
        cmp("R4 r after reset", r, '0);

        apply("R3 q", "R3 r", 32'h13579BDF, 32'h00002468);
        cmp("R3 q const", q, 32'h00008802);
        cmp("R3 r const", r, 32'h0000130F);

        apply("R4 q", "R4 r", 32'hDEADBEEF, 32'h0);
        apply("R4 q", "R4 r", 32'hFFFFFFFF, 32'h0);
        apply("R5 q", "R5 r", 32'hCAFEF00D, 32'h1);
        apply("R5 q", "R5 r", 32'hFFFFFFFF, 32'h1);
        apply("R6 q", "R6 r", 32'h00001234, 32'h00012345);
        apply("R6 q", "R6 r", 32'h7FFFFFFF, 32'h80000000);
        apply("R7 q", "R7 r", 32'hFFFFFFFF, 32'hFFFFFFFF);
        apply("R7 q", "R7 r", 32'h00000001, 32'h00000001);
        apply("R8 q", "R8 r", 32'hFFFFFFFF, 32'h80000000);
        apply("R8 q", "R8 r", 32'hFFFFFFFE, 32'hFFFFFFFF);
        apply("R8 q", "R8 r", 32'hFFFFFFFF, 32'h00000002);

        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = $urandom;
            rb = $urandom;
            case (i % 4)
                1: rb = rb >> (rb[4:0]);
                2: rb = {16'h0, rb[15:0]};
                3: rb = {24'h0, rb[7:0]};
                default: ;
            endcase
            apply("R1 q", "R2 r", ra, rb);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule